// File: doc/BRIEF.md
# PMIC Voltage Command Issuer

This block sits between software and a serial-bus master that talks to an external voltage regulator. It stores the regulator settings for each voltage channel: slave address, voltage register address, command register address, a five-bit selection word, and a table of four voltage select codes, one for each power state. From these it builds single register-write transactions for the bus master. The bus master itself, its electrical timing and any arbitration between channels are outside this block.

A transaction starts in one of two ways. Software can write a raw bypass command, which packs slave address, register address and data byte. A write with the start flag low only stores the fields. A second write with the flag high launches the command. The flag then reads back as set until the regulator answers. Hardware can also ask for a power-state change on one channel. In that case the block forms the transaction from the channel's selection word. Each selection bit picks either the channel's private setting or the setting of the default channel. One channel packs its selection word in a permuted bit order. The default channel keeps only its command-register-enable bit.

One transaction is outstanding at a time. The request to the bus master is held until an acknowledge or a no-acknowledge pulse arrives. A no-acknowledge sets a sticky error flag, which stays set until the next launch.

Top module: `pvc_issuer`

## Requirements
- R1: After reset every configuration register and the bypass register read 0, `bus_req` is low and `ps_grant` is low.
- R2: The bypass register is at address 4*NUM_CH and holds data in bits [7:0], register address in [15:8] and slave address in [22:16]. A write while idle with bit 24 (start flag) low stores these fields for readback and raises no request.
- R3: A write to the bypass register while idle with bit 24 high raises `bus_req` at the next clock edge, carrying the written fields, and bit 24 reads back as 1.
- R4: While `bus_req` is high and neither `bus_ack` nor `bus_nack` is high, `bus_req` stays high and slave, register and data outputs stay unchanged.
- R5: A `bus_ack` pulse during a request drops `bus_req` at the next edge, and bit 24 of the bypass register then reads 0.
- R6: A `bus_nack` pulse during a request drops `bus_req` and sets error bit 25 of the bypass register. The error bit stays set until the next transaction is launched, which clears it.
- R7: Any bypass write while a transaction is outstanding is ignored: the stored fields, the flags and the bus outputs are unchanged.
- R8: Each channel c has a command table at address 4c+2, with ON at [7:0], ON-low-power at [15:8], RETENTION at [23:16] and OFF at [31:24]. A power-state request with `ps_state` 0, 1, 2 or 3 sends the matching byte as data.
- R9: Each channel's selection word is at address 4c (bits [4:0]) and its addresses are at 4c+1 (slave [6:0], voltage register [15:8], command register [23:16]). In the standard layout, bit0 picks the private slave address, bit1 the private voltage register, bit2 the private command register, bit3 the command-register enable and bit4 the private command table. A clear bit means the default channel's value is used.
- R10: Channel PERMUTED_CH (default 1) uses the layout bit0 slave address, bit1 command table, bit2 voltage register, bit3 command register, bit4 enable.
- R11: For channel DEFAULT_CH (default 0) only the enable bit of its selection word is stored. Every other bit written is forced to 0.
- R12: The register address of a power-state transaction is the selected command register address when the channel's own enable bit is set, and the selected voltage register address otherwise.
- R13: `ps_grant` is high exactly in a cycle where `ps_req` is accepted, which launches a request at the next edge. A request is not accepted while a transaction is outstanding, nor in a cycle where a bypass launch is written: the bypass launch takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ps_req | input | 1 | Power-state command request |
| ps_chan | input | CH_W (2) | Channel of the power-state request |
| ps_state | input | 2 | Power state: 0 ON, 1 ON-low-power, 2 RETENTION, 3 OFF |
| ps_grant | output | 1 | Request accepted this cycle |
| bus_req | output | 1 | Write transaction outstanding toward the bus master |
| bus_slave | output | 7 | Slave address of the transaction |
| bus_reg | output | 8 | Regulator register address |
| bus_data | output | 8 | Data byte |
| bus_ack | input | 1 | Acknowledge pulse from the bus master |
| bus_nack | input | 1 | No-acknowledge pulse from the bus master |

## Verification
A wrong busy state shows at once in one of three ways: a request that drops before its answer, a second launch accepted while one is outstanding, or a start flag that never clears after the acknowledge. Each is visible on `bus_req`, `ps_grant` or bypass bit 24 within one cycle. A wrongly decoded selection word appears only later, on the first power-state request for that channel, as a wrong slave, register or data byte. For that reason the bench sweeps random selection words on every channel, including the permuted and default ones, and checks each formed transaction. A stale error flag is seen on the next bypass readback.

// File: rtl/pvc_pkg.sv
// Package: shared types, field positions and selection-word decoding for the
// voltage command issuer. Assumes a 5-bit selection word per channel.
package pvc_pkg;

    localparam int SEL_W       = 5;
    localparam int SA_W        = 7;
    localparam int RA_W        = 8;
    localparam int DATA_W      = 8;
    localparam int BYP_D_LSB   = 0;
    localparam int BYP_RA_LSB  = 8;
    localparam int BYP_SA_LSB  = 16;
    localparam int BYP_GO_BIT  = 24;
    localparam int BYP_ERR_BIT = 25;

    typedef struct packed {
        logic own_cmd;
        logic cra_en;
        logic own_cra;
        logic own_vra;
        logic own_sa;
    } chan_sel_t;

    typedef enum logic [1:0] {
        PS_ON   = 2'd0,
        PS_ONLP = 2'd1,
        PS_RET  = 2'd2,
        PS_OFF  = 2'd3
    } pstate_e;

    // Turn a raw selection word into named choices for either layout.
    function automatic chan_sel_t decode_sel(input logic [SEL_W-1:0] w,
                                             input logic permuted);
        chan_sel_t s;
        s.own_sa = w[0];
        if (permuted) begin
            s.own_cmd = w[1];
            s.own_vra = w[2];
            s.own_cra = w[3];
            s.cra_en  = w[4];
        end else begin
            s.own_vra = w[1];
            s.own_cra = w[2];
            s.cra_en  = w[3];
            s.own_cmd = w[4];
        end
        return s;
    endfunction

    // Position of the enable bit for the given layout.
    function automatic logic [SEL_W-1:0] enable_mask(input logic permuted);
        return permuted ? 5'b10000 : 5'b01000;
    endfunction

endpackage

// File: rtl/pvc_chan_regs.sv
// Module: per-channel storage of selection word, addresses and command table.
// Occupies four word addresses starting at 4*CH_IDX; the fourth reads as 0.
// Assumes writes are single-cycle strobes; reads are combinational.
module pvc_chan_regs
    import pvc_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int CH_IDX     = 0,
    parameter bit IS_DEFAULT = 1'b0,
    parameter bit PERMUTED   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [SEL_W-1:0]  sel_word,
    output logic [SA_W-1:0]   sa,
    output logic [RA_W-1:0]   vra,
    output logic [RA_W-1:0]   cra,
    output logic [31:0]       cmdval,
    output logic [31:0]       rd_data
);

    localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(CH_IDX * 4);
    localparam logic [ADDR_W-1:0] A_ADR  = ADDR_W'(CH_IDX * 4 + 1);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CH_IDX * 4 + 2);
    localparam logic [SEL_W-1:0]  KEEP   = IS_DEFAULT ? enable_mask(PERMUTED) : {SEL_W{1'b1}};

    logic unused_bits;
    assign unused_bits = ^{wr_data[31:24], wr_data[7]};

    // Selection word; the default channel keeps only its enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_word <= '0;
        else if (wr_en && addr == A_SEL)
            sel_word <= wr_data[SEL_W-1:0] & KEEP;
    end

    // Slave, voltage register and command register addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sa  <= '0;
            vra <= '0;
            cra <= '0;
        end else if (wr_en && addr == A_ADR) begin
            sa  <= wr_data[SA_W-1:0];
            vra <= wr_data[15:8];
            cra <= wr_data[23:16];
        end
    end

    // Four voltage select codes, one per power state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmdval <= '0;
        else if (wr_en && addr == A_CMD)
            cmdval <= wr_data;
    end

    // Readback of this channel's words, zero when not addressed.
    always_comb begin
        rd_data = '0;
        if (addr == A_SEL)
            rd_data = {27'd0, sel_word};
        else if (addr == A_ADR)
            rd_data = {8'd0, cra, vra, 1'b0, sa};
        else if (addr == A_CMD)
            rd_data = cmdval;
    end

endmodule

// File: rtl/pvc_sel_mux.sv
// Module: forms slave, register and data of a power-state transaction from
// the requested channel's selection word, falling back to the default
// channel's settings for every clear selection bit. Purely combinational.
module pvc_sel_mux
    import pvc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CH_W        = 2,
    parameter int DEFAULT_CH  = 0,
    parameter int PERMUTED_CH = 1
) (
    input  logic [SEL_W-1:0]  sel_word [NUM_CH],
    input  logic [SA_W-1:0]   sa       [NUM_CH],
    input  logic [RA_W-1:0]   vra      [NUM_CH],
    input  logic [RA_W-1:0]   cra      [NUM_CH],
    input  logic [31:0]       cmdval   [NUM_CH],
    input  logic [CH_W-1:0]   chan,
    input  logic [1:0]        state,
    output logic              chan_ok,
    output logic [SA_W-1:0]   out_sa,
    output logic [RA_W-1:0]   out_ra,
    output logic [DATA_W-1:0] out_data
);

    chan_sel_t   s;
    logic [31:0] tbl;
    logic [RA_W-1:0] vsel_ra, csel_ra;

    // Select the channel's fields and merge them with default-channel values.
    always_comb begin
        s        = '0;
        out_sa   = sa[DEFAULT_CH];
        vsel_ra  = vra[DEFAULT_CH];
        csel_ra  = cra[DEFAULT_CH];
        tbl      = cmdval[DEFAULT_CH];
        chan_ok  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (chan == CH_W'(i)) begin
                chan_ok = 1'b1;
                s       = decode_sel(sel_word[i], i == PERMUTED_CH);
                if (s.own_sa)  out_sa  = sa[i];
                if (s.own_vra) vsel_ra = vra[i];
                if (s.own_cra) csel_ra = cra[i];
                if (s.own_cmd) tbl     = cmdval[i];
            end
        end
        out_ra = s.cra_en ? csel_ra : vsel_ra;
        case (pstate_e'(state))
            PS_ON:   out_data = tbl[7:0];
            PS_ONLP: out_data = tbl[15:8];
            PS_RET:  out_data = tbl[23:16];
            default: out_data = tbl[31:24];
        endcase
    end

endmodule

// File: rtl/pvc_seq.sv
// Module: bypass register and single-outstanding transaction sequencer.
// Assumes bus_ack / bus_nack are one-cycle pulses and only matter while a
// request is outstanding.
module pvc_seq
    import pvc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byp_we,
    input  logic [31:0]       byp_wdata,
    input  logic              ps_ok,
    input  logic [SA_W-1:0]   ps_sa,
    input  logic [RA_W-1:0]   ps_ra,
    input  logic [DATA_W-1:0] ps_data,
    input  logic              bus_ack,
    input  logic              bus_nack,
    output logic              ps_grant,
    output logic              bus_req,
    output logic [SA_W-1:0]   bus_slave,
    output logic [RA_W-1:0]   bus_reg,
    output logic [DATA_W-1:0] bus_data,
    output logic [31:0]       byp_rdata,
    output logic              err_flag
);

    logic              busy_q, byp_own_q, err_q;
    logic [SA_W-1:0]   bsa_q;
    logic [RA_W-1:0]   bra_q;
    logic [DATA_W-1:0] bd_q;
    logic              idle, byp_store, byp_go, done;

    logic unused_bits;
    assign unused_bits = ^{byp_wdata[31:25], byp_wdata[23]};

    assign idle      = !busy_q;
    assign byp_store = byp_we && idle;
    assign byp_go    = byp_store && byp_wdata[BYP_GO_BIT];
    assign done      = busy_q && (bus_ack || bus_nack);
    assign ps_grant  = ps_ok && idle && !byp_go;

    // Stored bypass fields, frozen while a transaction is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsa_q <= '0;
            bra_q <= '0;
            bd_q  <= '0;
        end else if (byp_store) begin
            bsa_q <= byp_wdata[BYP_SA_LSB +: SA_W];
            bra_q <= byp_wdata[BYP_RA_LSB +: RA_W];
            bd_q  <= byp_wdata[BYP_D_LSB  +: DATA_W];
        end
    end

    // Outstanding flag and its origin (bypass or power-state request).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            byp_own_q <= 1'b0;
        end else if (byp_go || ps_grant) begin
            busy_q    <= 1'b1;
            byp_own_q <= byp_go;
        end else if (done) begin
            busy_q    <= 1'b0;
            byp_own_q <= 1'b0;
        end
    end

    // Transaction fields presented to the bus master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_slave <= '0;
            bus_reg   <= '0;
            bus_data  <= '0;
        end else if (byp_go) begin
            bus_slave <= byp_wdata[BYP_SA_LSB +: SA_W];
            bus_reg   <= byp_wdata[BYP_RA_LSB +: RA_W];
            bus_data  <= byp_wdata[BYP_D_LSB  +: DATA_W];
        end else if (ps_grant) begin
            bus_slave <= ps_sa;
            bus_reg   <= ps_ra;
            bus_data  <= ps_data;
        end
    end

    // Sticky no-acknowledge flag, cleared by the next launch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (byp_go || ps_grant)
            err_q <= 1'b0;
        else if (done && bus_nack)
            err_q <= 1'b1;
    end

    assign bus_req  = busy_q;
    assign err_flag = err_q;

    // Bypass register readback image.
    always_comb begin
        byp_rdata = '0;
        byp_rdata[BYP_D_LSB  +: DATA_W] = bd_q;
        byp_rdata[BYP_RA_LSB +: RA_W]   = bra_q;
        byp_rdata[BYP_SA_LSB +: SA_W]   = bsa_q;
        byp_rdata[BYP_GO_BIT]           = busy_q && byp_own_q;
        byp_rdata[BYP_ERR_BIT]          = err_q;
    end

endmodule

// File: rtl/pvc_issuer.sv
// Module: top of the voltage command issuer. Holds per-channel regulator
// settings, forms power-state and bypass write transactions and hands them
// one at a time to an external serial-bus master. Assumes a single clock and
// synchronous active-low reset.
module pvc_issuer
    import pvc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DEFAULT_CH  = 0,
    parameter int PERMUTED_CH = 1,
    parameter int CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ADDR_W      = $clog2(NUM_CH * 4 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ps_req,
    input  logic [CH_W-1:0]   ps_chan,
    input  logic [1:0]        ps_state,
    output logic              ps_grant,
    output logic              bus_req,
    output logic [6:0]        bus_slave,
    output logic [7:0]        bus_reg,
    output logic [7:0]        bus_data,
    input  logic              bus_ack,
    input  logic              bus_nack
);

    localparam logic [ADDR_W-1:0] BYP_ADDR    = ADDR_W'(NUM_CH * 4);
    localparam logic [SEL_W-1:0]  DEF_EN_MASK = enable_mask(DEFAULT_CH == PERMUTED_CH);

    logic [SEL_W-1:0] sel_word [NUM_CH];
    logic [SA_W-1:0]  sa_a     [NUM_CH];
    logic [RA_W-1:0]  vra_a    [NUM_CH];
    logic [RA_W-1:0]  cra_a    [NUM_CH];
    logic [31:0]      cmd_a    [NUM_CH];
    logic [31:0]      rd_a     [NUM_CH];
    logic [31:0]      byp_rdata;
    logic [SEL_W-1:0] def_cfg_word;
    logic             chan_ok, err_flag;
    logic [SA_W-1:0]  m_sa;
    logic [RA_W-1:0]  m_ra;
    logic [DATA_W-1:0] m_data;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            pvc_chan_regs #(
                .ADDR_W    (ADDR_W),
                .CH_IDX    (g),
                .IS_DEFAULT(g == DEFAULT_CH),
                .PERMUTED  (g == PERMUTED_CH)
            ) u_regs (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (reg_we),
                .addr    (reg_addr),
                .wr_data (reg_wdata),
                .sel_word(sel_word[g]),
                .sa      (sa_a[g]),
                .vra     (vra_a[g]),
                .cra     (cra_a[g]),
                .cmdval  (cmd_a[g]),
                .rd_data (rd_a[g])
            );
        end
    endgenerate

    assign def_cfg_word = sel_word[DEFAULT_CH];

    pvc_sel_mux #(
        .NUM_CH     (NUM_CH),
        .CH_W       (CH_W),
        .DEFAULT_CH (DEFAULT_CH),
        .PERMUTED_CH(PERMUTED_CH)
    ) u_mux (
        .sel_word(sel_word),
        .sa      (sa_a),
        .vra     (vra_a),
        .cra     (cra_a),
        .cmdval  (cmd_a),
        .chan    (ps_chan),
        .state   (ps_state),
        .chan_ok (chan_ok),
        .out_sa  (m_sa),
        .out_ra  (m_ra),
        .out_data(m_data)
    );

    pvc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .byp_we   (reg_we && reg_addr == BYP_ADDR),
        .byp_wdata(reg_wdata),
        .ps_ok    (ps_req && chan_ok),
        .ps_sa    (m_sa),
        .ps_ra    (m_ra),
        .ps_data  (m_data),
        .bus_ack  (bus_ack),
        .bus_nack (bus_nack),
        .ps_grant (ps_grant),
        .bus_req  (bus_req),
        .bus_slave(bus_slave),
        .bus_reg  (bus_reg),
        .bus_data (bus_data),
        .byp_rdata(byp_rdata),
        .err_flag (err_flag)
    );

    // Read mux: bypass register or the OR of the channel readbacks.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == BYP_ADDR)
            reg_rdata = byp_rdata;
        else
            for (int i = 0; i < NUM_CH; i++)
                reg_rdata = reg_rdata | rd_a[i];
    end

endmodule

// File: rtl/pvc_issuer_chk.sv
// Module: protocol and state checker for pvc_issuer, bound to every instance.
module pvc_issuer_chk #(
    parameter logic [4:0] EN_MASK = 5'b01000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_ack,
    input logic       bus_nack,
    input logic [6:0] bus_slave,
    input logic [7:0] bus_reg,
    input logic [7:0] bus_data,
    input logic       ps_grant,
    input logic       err_flag,
    input logic [4:0] def_cfg_word
);

    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_nack |=> bus_req && $stable(bus_slave)
                                            && $stable(bus_reg) && $stable(bus_data));

    a_r5_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack |=> !bus_req);

    a_r6_nack_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_nack |=> !bus_req && err_flag);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !bus_req |=> err_flag || bus_req);

    a_r13_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !ps_grant);

    a_r13_grant_launch: assert property (@(posedge clk) disable iff (!rst_n)
        ps_grant |=> bus_req);

    a_r11_default_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (def_cfg_word & ~EN_MASK) == 5'd0);

endmodule

bind pvc_issuer pvc_issuer_chk #(.EN_MASK(DEF_EN_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .bus_nack    (bus_nack),
    .bus_slave   (bus_slave),
    .bus_reg     (bus_reg),
    .bus_data    (bus_data),
    .ps_grant    (ps_grant),
    .err_flag    (err_flag),
    .def_cfg_word(def_cfg_word)
);

// File: tb/tb_pvc_issuer.sv
`timescale 1ns/1ps
module tb_pvc_issuer;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] BYP = 5'd16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ps_req = 1'b0;
    logic [1:0]  ps_chan = '0;
    logic [1:0]  ps_state = '0;
    logic        ps_grant, bus_req;
    logic [6:0]  bus_slave;
    logic [7:0]  bus_reg, bus_data;
    logic        bus_ack = 1'b0;
    logic        bus_nack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model of stored settings
    logic [4:0]  m_cfg [NUM_CH];
    logic [6:0]  m_sa  [NUM_CH];
    logic [7:0]  m_vra [NUM_CH];
    logic [7:0]  m_cra [NUM_CH];
    logic [31:0] m_cmd [NUM_CH];

    always #2 clk = ~clk;

    pvc_issuer dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ps_req(ps_req),
        .ps_chan(ps_chan), .ps_state(ps_state), .ps_grant(ps_grant),
        .bus_req(bus_req), .bus_slave(bus_slave), .bus_reg(bus_reg),
        .bus_data(bus_data), .bus_ack(bus_ack), .bus_nack(bus_nack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // model-side writes of channel settings
    task automatic set_cfg(input int c, input logic [4:0] w);
        reg_write(5'(c*4), {27'd0, w});
        m_cfg[c] = (c == 0) ? (w & 5'b01000) : w;
    endtask

    task automatic set_adr(input int c, input logic [6:0] s, input logic [7:0] v, input logic [7:0] k);
        reg_write(5'(c*4+1), {8'd0, k, v, 1'b0, s});
        m_sa[c] = s; m_vra[c] = v; m_cra[c] = k;
    endtask

    task automatic set_cmd(input int c, input logic [31:0] t);
        reg_write(5'(c*4+2), t);
        m_cmd[c] = t;
    endtask

    function automatic logic [22:0] exp_txn(input int c, input int st);
        logic [4:0] w;
        bit u_sa, u_cmd, u_vra, u_cra, en;
        logic [6:0] s; logic [7:0] v, k; logic [31:0] t; logic [7:0] d;
        w = m_cfg[c];
        u_sa = w[0];
        if (c == 1) begin u_cmd = w[1]; u_vra = w[2]; u_cra = w[3]; en = w[4]; end
        else        begin u_vra = w[1]; u_cra = w[2]; en = w[3]; u_cmd = w[4]; end
        s = u_sa  ? m_sa[c]  : m_sa[0];
        v = u_vra ? m_vra[c] : m_vra[0];
        k = u_cra ? m_cra[c] : m_cra[0];
        t = u_cmd ? m_cmd[c] : m_cmd[0];
        d = t[st*8 +: 8];
        return {s, en ? k : v, d};
    endfunction

    // Issue a power-state request and check grant and formed transaction.
    task automatic ps_issue(input string req, input int c, input int st);
        logic [22:0] e;
        e = exp_txn(c, st);
        @(negedge clk);
        ps_req = 1'b1; ps_chan = 2'(c); ps_state = 2'(st);
        #1 check({req, " grant"}, {31'd0, ps_grant}, 32'd1);
        @(negedge clk);
        ps_req = 1'b0;
        check({req, " req"}, {31'd0, bus_req}, 32'd1);
        check({req, " txn"}, {9'd0, bus_slave, bus_reg, bus_data}, {9'd0, e});
    endtask

    task automatic respond(input bit nack);
        @(negedge clk);
        bus_ack = !nack; bus_nack = nack;
        @(negedge clk);
        bus_ack = 1'b0; bus_nack = 1'b0;
        check("R5/R6 release", {31'd0, bus_req}, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] bv;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NUM_CH; i++) begin
            m_cfg[i] = '0; m_sa[i] = '0; m_vra[i] = '0; m_cra[i] = '0; m_cmd[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(BYP, rd);      check("R1 bypass", rd, 32'd0);
        reg_read(5'd0, rd);     check("R1 cfg0", rd, 32'd0);
        reg_read(5'd6, rd);     check("R1 cmd1", rd, 32'd0);
        check("R1 bus_req", {31'd0, bus_req}, 32'd0);
        check("R1 grant", {31'd0, ps_grant}, 32'd0);

        // R2 store without launch
        bv = (32'h12 << 16) | (32'h5A << 8) | 32'h3C;
        reg_write(BYP, bv);
        reg_read(BYP, rd);      check("R2 fields", rd, bv);
        check("R2 no req", {31'd0, bus_req}, 32'd0);

        // R3 launch
        reg_write(BYP, bv | (32'd1 << 24));
        check("R3 req", {31'd0, bus_req}, 32'd1);
        check("R3 txn", {9'd0, bus_slave, bus_reg, bus_data}, {9'd0, 7'h12, 8'h5A, 8'h3C});
        reg_read(BYP, rd);      check("R3 valid", rd, bv | (32'd1 << 24));

        // R4 hold
        repeat (3) @(negedge clk);
        check("R4 held", {31'd0, bus_req}, 32'd1);
        check("R4 stable", {9'd0, bus_slave, bus_reg, bus_data}, {9'd0, 7'h12, 8'h5A, 8'h3C});

        // R7 write while busy ignored
        reg_write(BYP, 32'h017F_FFFF);
        reg_read(BYP, rd);      check("R7 ignored", rd, bv | (32'd1 << 24));
        check("R7 bus", {9'd0, bus_slave, bus_reg, bus_data}, {9'd0, 7'h12, 8'h5A, 8'h3C});

        // R13 no grant while busy
        @(negedge clk);
        ps_req = 1'b1; ps_chan = 2'd2;
        #1 check("R13 busy no grant", {31'd0, ps_grant}, 32'd0);
        @(negedge clk); ps_req = 1'b0;

        // R5 ack
        respond(1'b0);
        reg_read(BYP, rd);      check("R5 valid clear", rd, bv);

        // R6 nack and sticky error
        reg_write(BYP, bv | (32'd1 << 24));
        respond(1'b1);
        reg_read(BYP, rd);      check("R6 err set", rd, bv | (32'd1 << 25));
        repeat (4) @(negedge clk);
        reg_read(BYP, rd);      check("R6 err sticky", rd, bv | (32'd1 << 25));
        reg_write(BYP, bv | (32'd1 << 24));
        reg_read(BYP, rd);      check("R6 err cleared", rd, bv | (32'd1 << 24));
        respond(1'b0);

        // R13 bypass launch wins over same-cycle request
        @(negedge clk);
        reg_we = 1'b1; reg_addr = BYP; reg_wdata = 32'h0103_0405;
        ps_req = 1'b1; ps_chan = 2'd0; ps_state = 2'd0;
        #1 check("R13 priority grant", {31'd0, ps_grant}, 32'd0);
        @(negedge clk);
        reg_we = 1'b0; ps_req = 1'b0;
        check("R13 priority txn", {9'd0, bus_slave, bus_reg, bus_data}, {9'd0, 7'h03, 8'h04, 8'h05});
        respond(1'b0);

        // directed channel settings
        set_adr(0, 7'h48, 8'h10, 8'h20);
        set_cmd(0, 32'h4433_2211);
        set_adr(2, 7'h4A, 8'h30, 8'h40);
        set_cmd(2, 32'hD4C3_B2A1);
        // R9 all private on channel 2, R8 every state
        set_cfg(2, 5'b10111);
        for (int st = 0; st < 4; st++) begin
            ps_issue("R8 R9 private", 2, st);
            respond(1'b0);
        end
        check("R8 ON byte", {24'd0, exp_txn(2, 0)[7:0]}, 32'hA1);
        // R9 all default on channel 2
        set_cfg(2, 5'b00000);
        ps_issue("R9 default fallback", 2, 3);
        respond(1'b0);
        // R12 enable selects command register
        set_cfg(2, 5'b01111);
        ps_issue("R12 cmd reg", 2, 1);
        respond(1'b0);
        check("R12 model", {24'd0, exp_txn(2, 1)[15:8]}, 32'h40);
        // R10 permuted channel 1: private command table only (bit1)
        set_adr(1, 7'h2C, 8'h55, 8'h66);
        set_cmd(1, 32'h8877_6655);
        set_cfg(1, 5'b00010);
        ps_issue("R10 permuted cmd", 1, 2);
        respond(1'b0);
        // R10 permuted enable at bit4 with private command register at bit3
        set_cfg(1, 5'b11001);
        ps_issue("R10 permuted en", 1, 0);
        respond(1'b0);
        // R11 default channel keeps only enable
        set_cfg(0, 5'b11111);
        reg_read(5'd0, rd);     check("R11 masked", rd, 32'h08);
        ps_issue("R11 default enable", 0, 0);
        respond(1'b0);

        // random mix
        for (int it = 0; it < 80; it++) begin
            int c;
            int st;
            c = int'($urandom_range(0, NUM_CH - 1));
            case ($urandom_range(0, 2))
                0: set_cfg(c, 5'($urandom));
                1: set_adr(c, 7'($urandom), 8'($urandom), 8'($urandom));
                default: set_cmd(c, $urandom);
            endcase
            reg_read(5'(c*4), rd);
            check("R9 R11 cfg readback", rd, {27'd0, m_cfg[c]});
            c  = int'($urandom_range(0, NUM_CH - 1));
            st = int'($urandom_range(0, 3));
            ps_issue("R8 R9 R10 R12 random", c, st);
            if ($urandom_range(0, 3) == 0) begin
                respond(1'b1);
                reg_read(BYP, rd);
                check("R6 random err", {31'd0, rd[25]}, 32'd1);
            end else begin
                respond(1'b0);
                reg_read(BYP, rd);
                check("R5 random valid", {31'd0, rd[24]}, 32'd0);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule